// File: doc/BRIEF.md
# Station-Name Label Scroller

This block produces the eight-character label that a broadcast data encoder sends as the station name. While idle it passes a fixed static name straight through. When a length is written, it runs a pass over a dynamic text of up to `MAX_LEN` characters. Each pass shows a sequence of eight-character windows taken from that text. Once the pass ends, the block returns to the static name for a programmable gap and then runs the text again. A special gap value makes the pass run once only.

Four windowing modes set how the window moves through the text:

- **Mode 0:** fixed pages of eight characters.
- **Mode 1:** one-character steps.
- **Mode 2:** pages that avoid splitting words.
- **Mode 3:** one-character steps over the text with eight blanks added on each side.

Time is counted in pulses of the `tick` input. The label period sets the dwell of each page. The speed bit sets the dwell of each step. The static period sets the gap between passes. The group assembler reads `label` and `running` as plain levels.

Character `i` of any label or text sits at bits `[8*i+7:8*i]`, and `i = 0` is the leftmost character.

Top module: `ns_label_scroller`

## Requirements
- R1: After reset, `running` is 0. Whenever `running` is 0, `label` equals `static_name`.
- R2: In mode 0 (`mode` = 0), the window starts are 0, 8, 16 and so on, for every start below the length. Each window is held for `label_period`+1 ticks. A window position at or beyond the length reads 0x20.
- R3: In mode 1 (`mode` = 1), the window starts are 0, 1, 2, … up to length−8, each shown for one step dwell.
- R4: The step dwell used in modes 1 and 3 is `FAST_TICKS` ticks (default 1) when `fast_scroll` is 1, and `SLOW_TICKS` ticks (default 2) when it is 0.
- R5: Mode 2 (`mode` = 2) builds its pages one at a time from a page start p:
  - If p+8 ≥ length, the page is the last one and shows characters from p up to the end of the text.
  - Otherwise, let j be the largest value in 1..8 for which character p+j is 0x20. The page shows j characters, pads with blanks, and the next page starts at p+j+1.
  - If no such j exists, the page shows 8 characters and the next page starts at p+8.
  - The pass ends when the next start reaches the length. Each page is held for `label_period`+1 ticks.
- R6: In mode 3 (`mode` = 3), the text is padded with eight 0x20 characters before and after it. The window starts run from 1 to length+7 over that padded string, one step dwell each.
- R7: After the last window, `running` drops for (`static_period`+1)·`SP_MULT` ticks while the static name is shown. A new pass then starts in the mode currently set.
- R8: With `static_period` = 255, the block stays on the static name after a pass until the next length write.
- R9: A `len_wr` pulse restarts the pass from its first window on the next cycle, whatever the current state. A written length of 0 shows only the static name until the next write.
- R10: `running` is 1 exactly while dynamic windows are shown. Neither `label` nor `running` changes in a cycle that has no tick, no length write and no text change.
- R11: A written length above `MAX_LEN` is treated as `MAX_LEN`.
- R12: In mode 1, a length of 8 or less gives a single window at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One timing unit per pulse |
| len_wr | input | 1 | Length write strobe; restarts the loop |
| wr_len | input | LEN_W (7) | Length written with `len_wr` |
| mode | input | 2 | Windowing mode, 0 to 3 |
| label_period | input | 8 | Page dwell for modes 0 and 2, in ticks minus one |
| static_period | input | 8 | Gap between passes; 255 selects one-shot |
| fast_scroll | input | 1 | Step speed for modes 1 and 3 |
| static_name | input | 64 | Static eight-character name |
| dyn_text | input | 8·MAX_LEN | Dynamic text buffer |
| label | output | 64 | Current eight-character label |
| running | output | 1 | 1 while the dynamic text is displayed |

## Verification
Every result is due one clock after the edge that samples its cause. This covers a length write starting a pass, a tick ending a window, a gap ending, and a pass ending. The label itself follows the registered window position and the live text through combinational logic, so it shows in that same cycle. The bench changes inputs on the falling edge and advances its queue-based model on the rising edge. It then compares `label` and `running` one nanosecond after each falling edge, a point where both the design and the model have settled for that cycle.

// File: rtl/ns_scroll_pkg.sv
package ns_scroll_pkg;

    localparam int          LABEL_CHARS = 8;
    localparam int          CHAR_W      = 8;
    localparam logic [7:0]  BLANK       = 8'h20;
    localparam logic [7:0]  ONE_SHOT    = 8'hFF;

    typedef enum logic [1:0] {
        SM_PAGE = 2'd0,
        SM_STEP = 2'd1,
        SM_WORD = 2'd2,
        SM_PAD  = 2'd3
    } scroll_mode_e;

    typedef enum logic [1:0] {
        PH_STATIC = 2'd0,
        PH_DYN    = 2'd1,
        PH_GAP    = 2'd2
    } phase_e;

    // Ticks a window stays up, for the given mode and settings.
    function automatic int unsigned win_dwell(scroll_mode_e m, logic [7:0] lp,
                                              logic fast, int unsigned fast_t,
                                              int unsigned slow_t);
        if (m == SM_PAGE || m == SM_WORD)
            return int'(lp) + 1;
        return fast ? fast_t : slow_t;
    endfunction

    // First window start of a pass.
    function automatic int first_pos(scroll_mode_e m);
        return (m == SM_PAD) ? 1 : 0;
    endfunction

endpackage

// File: rtl/ns_break_finder.sv
module ns_break_finder
    import ns_scroll_pkg::*;
#(
    parameter int MAX_LEN = 72,
    parameter int IDX_W   = 7,
    parameter int LEN_W   = 7
)(
    input  logic [MAX_LEN*CHAR_W-1:0] dyn_text,
    input  logic [LEN_W-1:0]          len,
    input  logic [IDX_W-1:0]          pos,
    output logic [3:0]                page_lim,
    output logic [IDX_W-1:0]          page_next
);
    localparam int SLOTS = 2 ** IDX_W;

    logic [7:0] chars [SLOTS];

    for (genvar k = 0; k < SLOTS; k++) begin : g_chars
        if (k < MAX_LEN) begin : g_real
            assign chars[k] = dyn_text[k*CHAR_W +: CHAR_W];
        end else begin : g_pad
            assign chars[k] = BLANK;
        end
    end

    logic       at_end;
    logic       found;
    logic [3:0] cut;

    assign at_end = (int'(pos) + LABEL_CHARS) >= int'(len);

    // Largest j in 1..8 with a blank right after the first j characters.
    always_comb begin
        found = 1'b0;
        cut   = 4'd8;
        for (int j = 1; j <= LABEL_CHARS; j++) begin
            if (chars[pos + IDX_W'(j)] == BLANK) begin
                found = 1'b1;
                cut   = 4'(j);
            end
        end
    end

    always_comb begin
        if (at_end || !found) begin
            page_lim  = 4'd8;
            page_next = pos + IDX_W'(LABEL_CHARS);
        end else begin
            page_lim  = cut;
            page_next = pos + IDX_W'(cut) + IDX_W'(1);
        end
    end

endmodule

// File: rtl/ns_window_builder.sv
module ns_window_builder
    import ns_scroll_pkg::*;
#(
    parameter int MAX_LEN = 72,
    parameter int IDX_W   = 7,
    parameter int LEN_W   = 7
)(
    input  logic [MAX_LEN*CHAR_W-1:0]      dyn_text,
    input  logic [LABEL_CHARS*CHAR_W-1:0]  static_name,
    input  logic [LEN_W-1:0]               len,
    input  logic [IDX_W-1:0]               pos,
    input  scroll_mode_e                   mode_l,
    input  logic [3:0]                     lim,
    input  logic                           show_dyn,
    output logic [LABEL_CHARS*CHAR_W-1:0]  label
);
    localparam int SLOTS = 2 ** IDX_W;

    logic [7:0] chars [SLOTS];

    for (genvar k = 0; k < SLOTS; k++) begin : g_chars
        if (k < MAX_LEN) begin : g_real
            assign chars[k] = dyn_text[k*CHAR_W +: CHAR_W];
        end else begin : g_pad
            assign chars[k] = BLANK;
        end
    end

    for (genvar i = 0; i < LABEL_CHARS; i++) begin : g_slot
        logic [IDX_W-1:0] eff;
        logic [IDX_W-1:0] src;
        logic             valid;

        assign eff = pos + IDX_W'(i);

        always_comb begin
            if (mode_l == SM_PAD) begin
                src   = eff - IDX_W'(LABEL_CHARS);
                valid = (int'(eff) >= LABEL_CHARS) &&
                        ((int'(eff) - LABEL_CHARS) < int'(len));
            end else begin
                src   = eff;
                valid = (int'(eff) < int'(len)) && (i < int'(lim));
            end
        end

        assign label[i*CHAR_W +: CHAR_W] =
            !show_dyn ? static_name[i*CHAR_W +: CHAR_W] :
            valid     ? chars[src] : BLANK;
    end

endmodule

// File: rtl/ns_pass_sequencer.sv
module ns_pass_sequencer
    import ns_scroll_pkg::*;
#(
    parameter int MAX_LEN    = 72,
    parameter int IDX_W      = 7,
    parameter int LEN_W      = 7,
    parameter int FAST_TICKS = 1,
    parameter int SLOW_TICKS = 2,
    parameter int SP_MULT    = 5
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              len_wr,
    input  logic [LEN_W-1:0]  wr_len,
    input  scroll_mode_e      mode,
    input  logic [7:0]        label_period,
    input  logic [7:0]        static_period,
    input  logic              fast_scroll,
    input  logic [IDX_W-1:0]  page_next,
    output phase_e            phase,
    output logic [IDX_W-1:0]  pos,
    output scroll_mode_e      mode_l,
    output logic [LEN_W-1:0]  len_l
);
    localparam int GAP_MAX = 256 * SP_MULT;
    localparam int CNT_MAX = (GAP_MAX > SLOW_TICKS) ? GAP_MAX : SLOW_TICKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] len_clamped;
    logic             last_win;
    logic [IDX_W-1:0] nxt_pos;
    logic [CNT_W-1:0] dwell_new;
    logic [CNT_W-1:0] dwell_cur;
    logic [CNT_W-1:0] gap_len;

    assign len_clamped = (int'(wr_len) > MAX_LEN) ? LEN_W'(MAX_LEN) : wr_len;

    assign dwell_new = CNT_W'(win_dwell(mode, label_period, fast_scroll,
                                        FAST_TICKS, SLOW_TICKS));
    assign dwell_cur = CNT_W'(win_dwell(mode_l, label_period, fast_scroll,
                                        FAST_TICKS, SLOW_TICKS));
    assign gap_len   = CNT_W'((int'(static_period) + 1) * SP_MULT);

    always_comb begin
        unique case (mode_l)
            SM_PAGE: begin
                last_win = (int'(pos) + LABEL_CHARS) >= int'(len_l);
                nxt_pos  = pos + IDX_W'(LABEL_CHARS);
            end
            SM_STEP: begin
                last_win = (int'(pos) + LABEL_CHARS) >= int'(len_l);
                nxt_pos  = pos + IDX_W'(1);
            end
            SM_WORD: begin
                last_win = ((int'(pos) + LABEL_CHARS) >= int'(len_l)) ||
                           (int'(page_next) >= int'(len_l));
                nxt_pos  = page_next;
            end
            default: begin
                last_win = int'(pos) >= (int'(len_l) + LABEL_CHARS - 1);
                nxt_pos  = pos + IDX_W'(1);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_STATIC;
            pos    <= '0;
            cnt    <= '0;
            mode_l <= SM_PAGE;
            len_l  <= '0;
        end else if (len_wr) begin
            len_l <= len_clamped;
            if (len_clamped == '0) begin
                phase <= PH_STATIC;
            end else begin
                phase  <= PH_DYN;
                mode_l <= mode;
                pos    <= IDX_W'(first_pos(mode));
                cnt    <= dwell_new;
            end
        end else if (tick) begin
            unique case (phase)
                PH_DYN: begin
                    if (cnt > CNT_W'(1)) begin
                        cnt <= cnt - CNT_W'(1);
                    end else if (last_win) begin
                        if (static_period == ONE_SHOT) begin
                            phase <= PH_STATIC;
                        end else begin
                            phase <= PH_GAP;
                            cnt   <= gap_len;
                        end
                    end else begin
                        pos <= nxt_pos;
                        cnt <= dwell_cur;
                    end
                end
                PH_GAP: begin
                    if (cnt > CNT_W'(1)) begin
                        cnt <= cnt - CNT_W'(1);
                    end else begin
                        phase  <= PH_DYN;
                        mode_l <= mode;
                        pos    <= IDX_W'(first_pos(mode));
                        cnt    <= dwell_new;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ns_label_scroller.sv
module ns_label_scroller
    import ns_scroll_pkg::*;
#(
    parameter int MAX_LEN    = 72,
    parameter int FAST_TICKS = 1,
    parameter int SLOW_TICKS = 2,
    parameter int SP_MULT    = 5,
    parameter int LEN_W      = $clog2(MAX_LEN + 1)
)(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           tick,
    input  logic                           len_wr,
    input  logic [LEN_W-1:0]               wr_len,
    input  logic [1:0]                     mode,
    input  logic [7:0]                     label_period,
    input  logic [7:0]                     static_period,
    input  logic                           fast_scroll,
    input  logic [LABEL_CHARS*CHAR_W-1:0]  static_name,
    input  logic [MAX_LEN*CHAR_W-1:0]      dyn_text,
    output logic [LABEL_CHARS*CHAR_W-1:0]  label,
    output logic                           running
);
    localparam int IDX_W = $clog2(MAX_LEN + 2 * LABEL_CHARS + 1);

    phase_e           phase;
    logic [IDX_W-1:0] pos;
    scroll_mode_e     mode_l;
    logic [LEN_W-1:0] len_l;
    logic [3:0]       page_lim;
    logic [IDX_W-1:0] page_next;
    logic [3:0]       win_lim;

    ns_pass_sequencer #(
        .MAX_LEN(MAX_LEN), .IDX_W(IDX_W), .LEN_W(LEN_W),
        .FAST_TICKS(FAST_TICKS), .SLOW_TICKS(SLOW_TICKS), .SP_MULT(SP_MULT)
    ) u_seq (
        .clk(clk), .rst(rst), .tick(tick), .len_wr(len_wr), .wr_len(wr_len),
        .mode(scroll_mode_e'(mode)), .label_period(label_period),
        .static_period(static_period), .fast_scroll(fast_scroll),
        .page_next(page_next), .phase(phase), .pos(pos),
        .mode_l(mode_l), .len_l(len_l)
    );

    ns_break_finder #(
        .MAX_LEN(MAX_LEN), .IDX_W(IDX_W), .LEN_W(LEN_W)
    ) u_brk (
        .dyn_text(dyn_text), .len(len_l), .pos(pos),
        .page_lim(page_lim), .page_next(page_next)
    );

    assign win_lim = (mode_l == SM_WORD) ? page_lim : 4'd8;
    assign running = (phase == PH_DYN);

    ns_window_builder #(
        .MAX_LEN(MAX_LEN), .IDX_W(IDX_W), .LEN_W(LEN_W)
    ) u_win (
        .dyn_text(dyn_text), .static_name(static_name), .len(len_l),
        .pos(pos), .mode_l(mode_l), .lim(win_lim), .show_dyn(running),
        .label(label)
    );

endmodule

// File: rtl/ns_label_scroller_chk.sv
module ns_label_scroller_chk #(
    parameter int MAX_LEN = 72,
    parameter int LEN_W   = 7
)(
    input logic                    clk,
    input logic                    rst,
    input logic                    tick,
    input logic                    len_wr,
    input logic [LEN_W-1:0]        wr_len,
    input logic [63:0]             static_name,
    input logic [MAX_LEN*8-1:0]    dyn_text,
    input logic [63:0]             label,
    input logic                    running
);
    a_r1_static_passthrough: assert property (@(posedge clk) disable iff (rst)
        !running |-> label == static_name);

    a_r9_zero_len_static: assert property (@(posedge clk) disable iff (rst)
        (len_wr && wr_len == '0) |=> !running);

    a_r9_restart_runs: assert property (@(posedge clk) disable iff (rst)
        (len_wr && wr_len != '0) |=> running);

    a_r10_run_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !len_wr) |=> $stable(running));

    a_r10_label_hold: assert property (@(posedge clk) disable iff (rst)
        (running && !tick && !len_wr) |=> (!$stable(dyn_text) || $stable(label)));

    a_r10_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> ($past(len_wr) || $past(tick)));
endmodule

bind ns_label_scroller ns_label_scroller_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .len_wr(len_wr), .wr_len(wr_len),
    .static_name(static_name), .dyn_text(dyn_text), .label(label),
    .running(running)
);

// File: tb/tb_ns_label_scroller.sv
`timescale 1ns/1ps
module tb_ns_label_scroller;
    localparam int MAX_LEN = 72;
    localparam int FAST_T  = 1;
    localparam int SLOW_T  = 2;
    localparam int SPM     = 5;
    localparam int LEN_W   = 7;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 tick = 1'b0;
    logic                 len_wr = 1'b0;
    logic [LEN_W-1:0]     wr_len = '0;
    logic [1:0]           mode = 2'd0;
    logic [7:0]           label_period = 8'd1;
    logic [7:0]           static_period = 8'd1;
    logic                 fast_scroll = 1'b1;
    logic [63:0]          static_name;
    logic [MAX_LEN*8-1:0] dyn_text;
    logic [63:0]          label;
    logic                 running;

    ns_label_scroller #(.MAX_LEN(MAX_LEN), .FAST_TICKS(FAST_T),
                        .SLOW_TICKS(SLOW_T), .SP_MULT(SPM)) dut (
        .clk(clk), .rst(rst), .tick(tick), .len_wr(len_wr), .wr_len(wr_len),
        .mode(mode), .label_period(label_period), .static_period(static_period),
        .fast_scroll(fast_scroll), .static_name(static_name),
        .dyn_text(dyn_text), .label(label), .running(running)
    );

    always #4 clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    string cur_req  = "R1";
    byte   txt [MAX_LEN];
    byte   sname [8];

    // ---------------- reference model ----------------
    int m_phase = 0;   // 0 static, 1 dynamic, 2 gap
    int m_cnt, m_len, m_mode, cur_p, cur_lim;
    int q_pos[$];
    int q_lim[$];

    function automatic int m_dwell();
        if (m_mode == 0 || m_mode == 2) return int'(label_period) + 1;
        return fast_scroll ? FAST_T : SLOW_T;
    endfunction

    function automatic void begin_pass();
        int p;
        m_mode = int'(mode);
        q_pos.delete(); q_lim.delete();
        case (m_mode)
            0: for (int s = 0; s < m_len; s += 8) begin q_pos.push_back(s); q_lim.push_back(8); end
            1: for (int s = 0; s <= ((m_len > 8) ? m_len - 8 : 0); s++) begin q_pos.push_back(s); q_lim.push_back(8); end
            3: for (int s = 1; s <= m_len + 7; s++) begin q_pos.push_back(s); q_lim.push_back(8); end
            default: begin
                p = 0;
                while (p < m_len) begin
                    int j;
                    if (p + 8 >= m_len) begin q_pos.push_back(p); q_lim.push_back(8); break; end
                    j = 0;
                    for (int c = 8; c >= 1; c--) if (j == 0 && txt[p + c] == 8'h20) j = c;
                    if (j != 0) begin q_pos.push_back(p); q_lim.push_back(j); p = p + j + 1; end
                    else begin q_pos.push_back(p); q_lim.push_back(8); p = p + 8; end
                end
            end
        endcase
        cur_p = q_pos.pop_front(); cur_lim = q_lim.pop_front();
        m_cnt = m_dwell();
        m_phase = 1;
    endfunction

    function automatic void end_pass();
        if (static_period == 8'hFF) m_phase = 0;
        else begin m_phase = 2; m_cnt = (int'(static_period) + 1) * SPM; end
    endfunction

    always @(posedge clk) begin
        if (rst) m_phase = 0;
        else if (len_wr) begin
            m_len = (int'(wr_len) > MAX_LEN) ? MAX_LEN : int'(wr_len);
            if (m_len == 0) m_phase = 0; else begin_pass();
        end else if (tick) begin
            if (m_phase == 1) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    if (q_pos.size() == 0) end_pass();
                    else begin cur_p = q_pos.pop_front(); cur_lim = q_lim.pop_front(); m_cnt = m_dwell(); end
                end
            end else if (m_phase == 2) begin
                m_cnt--;
                if (m_cnt == 0) begin_pass();
            end
        end
    end

    function automatic logic [63:0] exp_label();
        logic [63:0] r;
        for (int i = 0; i < 8; i++) begin
            byte ch;
            if (m_phase != 1) ch = sname[i];
            else if (m_mode == 3) begin
                int v = cur_p + i;
                ch = (v >= 8 && v - 8 < m_len) ? txt[v - 8] : 8'h20;
            end else ch = (i < cur_lim && cur_p + i < m_len) ? txt[cur_p + i] : 8'h20;
            r[i*8 +: 8] = ch;
        end
        return r;
    endfunction

    // ---------------- checking ----------------
    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            check(label == exp_label(), cur_req, "label", label, exp_label());
            check(running == (m_phase == 1), (cur_req == "R7" || cur_req == "R8") ? cur_req : "R10",
                  "running", 64'(running), 64'(m_phase == 1));
        end
    end

    // ---------------- stimulus ----------------
    function automatic void pack();
        for (int k = 0; k < MAX_LEN; k++) dyn_text[k*8 +: 8] = txt[k];
        for (int k = 0; k < 8; k++) static_name[k*8 +: 8] = sname[k];
    endfunction

    task automatic set_text(string s);
        for (int k = 0; k < MAX_LEN; k++) txt[k] = (k < s.len()) ? s[k] : 8'h23;
        pack();
    endtask

    task automatic write_len(int n);
        @(negedge clk); len_wr = 1'b1; wr_len = LEN_W'(n);
        @(negedge clk); len_wr = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(negedge clk); tick = 1'b0;
            @(negedge clk);
            @(negedge clk); tick = 1'b1;
        end
    end

    initial begin
        string nm;
        nm = "STATION1";
        for (int k = 0; k < 8; k++) sname[k] = nm[k];
        set_text("");
        run(3);
        @(negedge clk); rst = 1'b0;
        #1;
        check(running == 1'b0, "R1", "reset running", 64'(running), 64'd0);
        check(label == static_name, "R1", "reset label", label, static_name);

        cur_req = "R2"; mode = 2'd0; label_period = 8'd1; static_period = 8'd1;
        set_text("HELLO WORLD FROM RADIO"); write_len(22); run(60);
        cur_req = "R7"; run(140);

        cur_req = "R3"; mode = 2'd1; fast_scroll = 1'b0;
        set_text("ABCDEFGHIJKL"); write_len(12); run(60);
        cur_req = "R4"; fast_scroll = 1'b1; write_len(12); run(60);

        cur_req = "R5"; mode = 2'd2; label_period = 8'd0;
        set_text("TO BE OR NOT TO BE SUPERCALIFRAGILISTIC X"); write_len(41); run(200);

        cur_req = "R6"; mode = 2'd3; fast_scroll = 1'b0;
        set_text("NEWS"); write_len(4); run(160);

        cur_req = "R12"; mode = 2'd1; fast_scroll = 1'b1;
        set_text("SHORT"); write_len(5); run(60);

        cur_req = "R8"; mode = 2'd0; static_period = 8'hFF;
        set_text("HELLO WORLD FROM RADIO"); write_len(22); run(150);
        check(running == 1'b0, "R8", "one-shot settled", 64'(running), 64'd0);
        check(label == static_name, "R8", "one-shot label", label, static_name);

        cur_req = "R9"; static_period = 8'd2; write_len(22); run(10);
        write_len(22); #1;
        check(running == 1'b1, "R9", "restart running", 64'(running), 64'd1);
        run(10); write_len(0); #1;
        check(running == 1'b0, "R9", "zero length", 64'(running), 64'd0);
        run(60);

        cur_req = "R11"; static_period = 8'd1;
        for (int k = 0; k < MAX_LEN; k++) txt[k] = 8'h41 + (k % 26);
        pack(); write_len(100); run(150);

        cur_req = "R1"; nm = "NEWNAME!";
        for (int k = 0; k < 8; k++) sname[k] = nm[k];
        pack(); write_len(0); run(5);
        check(label == static_name, "R1", "live static name", label, static_name);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule